// File: doc/BRIEF.md
# Host Watchdog Control-Register File

This block holds the control bits of a power converter in a small register file and watches the host. The host must restart a programmable timer at regular intervals. The timer counts pulses on a prescaled tick input, and a parameter sets how many ticks make one second. If the host stops restarting the timer, the timer expires. On expiry the block returns a fixed group of control bits to safe values, sets a status bit and raises a sticky event flag.

The charge enable is handled on its own. After an expiry it takes the value of a separate behaviour bit, which the host can program. Bits outside the watchdog group keep their values through an expiry. These are that behaviour bit, the one-shot conversion select and the timeout period.

Software reaches the block through a strobed register port. The port has a 4-bit word address, 16-bit write data and 16-bit registered read data. The port also carries two command bits that read back as zero. One restarts the timer. The other resets the whole register file to its defaults.

Top module: `hostwd_regfile`

## Requirements
- R1: The period field is TIMER (address 1) bits [1:0] and resets to 01. A code of 01, 10 or 11 gives a timeout of 40, 80 or 160 seconds. The timer expires on the 40·S-th, 80·S-th or 160·S-th tick counted after the timer was last reloaded, where S is the number of ticks per second.
- R2: Writing TIMER with bit 2 set reloads the count to zero and clears the watchdog status. Bit 2 always reads back as 0.
- R3: On expiry `wd_status` is set. `wd_flag` is set on the rising edge of `wd_status`. Reading STATUS (address 4) returns {flag in bit 1, status in bit 0} and clears the flag, unless the same edge sets it again.
- R4: Expiry clears the following outputs: `hiz_en`, `rev_en`, `bypass_en`, `adc_en`, `load_out_en` and `load_in_en`. It sets `iout_pin_en` and `iin_pin_en` to 1 and sets `ilim_code` to 0x190.
- R5: On expiry `chg_en` takes the value of CONV (address 2) bit 3, which resets to 1. The other CONV bits are: bit 0 charge enable, bit 1 output load enable, bit 2 high-impedance enable.
- R6: Expiry leaves three bits unchanged: CONV bit 3, PATH bit 6 (the one-shot select, reset value 1) and the period field. PATH (address 3) holds the following bits: bit 0 reverse, bit 1 input load, bit 2 bypass, bit 3 ADC, bit 4 output-current pin enable, bit 5 input-current pin enable.
- R7: ILIM (address 0) bits [8:0] hold `ilim_code`, which resets to 0x190. A written value below 0x08 is stored as 0x08 and a value above 0x190 is stored as 0x190. Write data bits [15:9] are ignored.
- R8: Writing PATH with bit 7 set returns every register to its reset value, including the period, the timer count, the status and the flag. The other data bits of that write are ignored, and bit 7 reads as 0.
- R9: A period of 00 holds the count at zero, so the timer never expires. A write that changes the period restarts the count from zero without clearing the status.
- R10: After `rst_n` is released, every output shows its reset value: `chg_en`=1, both pin enables=1, `ilim_code`=0x190, and all other outputs 0.
- R11: `rdata` is registered. It shows the addressed word on the cycle after `rd_en` and holds its value otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled timer tick, one cycle wide |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| chg_en | output | 1 | Charge enable |
| hiz_en | output | 1 | High-impedance enable |
| rev_en | output | 1 | Reverse-mode enable |
| bypass_en | output | 1 | Bypass enable |
| adc_en | output | 1 | ADC enable |
| iout_pin_en | output | 1 | Output-current pin function enable |
| iin_pin_en | output | 1 | Input-current pin function enable |
| load_out_en | output | 1 | Output load sink enable |
| load_in_en | output | 1 | Input load sink enable |
| ilim_code | output | 9 | Output current limit, 50 mA per step |
| wd_status | output | 1 | Watchdog expired status |
| wd_flag | output | 1 | Sticky expiry event flag |

## Verification
The assertions check four things on every cycle:
- the group restore and the programmed charge value on the cycle after any expiry,
- the clamp window of the current limit,
- the flag following a rising status,
- the effects of a restart, of a soft reset and of a zero period on the next state.

Other properties depend on elapsed time, so only the bench scenarios show them:
- the exact tick at which each period expires,
- a count restarting when the period changes mid-count,
- clear-on-read of the flag,
- bits outside the group surviving an expiry.

A cycle-by-cycle reference model compares every output, read data included, through directed and random traffic.

// File: rtl/hostwd_pkg.sv
package hostwd_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int ILIM_W = 9;
  localparam int PER_W  = 2;

  localparam logic [ADDR_W-1:0] A_ILIM  = 4'd0;
  localparam logic [ADDR_W-1:0] A_TIMER = 4'd1;
  localparam logic [ADDR_W-1:0] A_CONV  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PATH  = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd4;

  localparam logic [ILIM_W-1:0] ILIM_MIN = 9'h008;
  localparam logic [ILIM_W-1:0] ILIM_MAX = 9'h190;
  localparam logic [PER_W-1:0]  PER_DEF  = 2'b01;

  // bit positions inside the command-bearing words
  localparam int TIMER_RESTART_BIT = 2;
  localparam int PATH_SOFTRST_BIT  = 7;

  typedef struct packed {
    logic              chg;
    logic              chg_wd_val;
    logic              load_out;
    logic              hiz;
    logic              rev;
    logic              load_in;
    logic              bypass;
    logic              adc;
    logic              adc_oneshot;
    logic              pin_iout;
    logic              pin_iin;
    logic [ILIM_W-1:0] ilim;
  } ctrl_t;

  function automatic logic [ILIM_W-1:0] clamp_ilim(input logic [ILIM_W-1:0] v);
    if (v < ILIM_MIN)      return ILIM_MIN;
    else if (v > ILIM_MAX) return ILIM_MAX;
    else                   return v;
  endfunction

  function automatic ctrl_t ctrl_default();
    ctrl_t c;
    c.chg         = 1'b1;
    c.chg_wd_val  = 1'b1;
    c.load_out    = 1'b0;
    c.hiz         = 1'b0;
    c.rev         = 1'b0;
    c.load_in     = 1'b0;
    c.bypass      = 1'b0;
    c.adc         = 1'b0;
    c.adc_oneshot = 1'b1;
    c.pin_iout    = 1'b1;
    c.pin_iin     = 1'b1;
    c.ilim        = ILIM_MAX;
    return c;
  endfunction

  // Restore only the watchdog group; other fields pass through.
  function automatic ctrl_t ctrl_wd_restore(input ctrl_t c);
    ctrl_t r;
    r          = c;
    r.chg      = c.chg_wd_val;
    r.load_out = 1'b0;
    r.hiz      = 1'b0;
    r.rev      = 1'b0;
    r.load_in  = 1'b0;
    r.bypass   = 1'b0;
    r.adc      = 1'b0;
    r.pin_iout = 1'b1;
    r.pin_iin  = 1'b1;
    r.ilim     = ILIM_MAX;
    return r;
  endfunction

  // Timeout length in ticks for a period code; zero means disabled.
  function automatic int unsigned wd_span(input logic [PER_W-1:0] p,
                                          input int unsigned tps,
                                          input int unsigned base_sec);
    case (p)
      2'b01:   return base_sec * tps;
      2'b10:   return 2 * base_sec * tps;
      2'b11:   return 4 * base_sec * tps;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/hostwd_timer.sv
module hostwd_timer
  import hostwd_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned BASE_SEC      = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic [PER_W-1:0] cfg_period,
  input  logic             cfg_restart,
  output logic [PER_W-1:0] period,
  output logic             expire_pulse,
  output logic             wd_status
);

  localparam int unsigned MAX_TICKS = TICKS_PER_SEC * BASE_SEC * 4;
  localparam int          CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_last;
  logic             reload;
  logic             at_last;

  assign lim_last = CNT_W'(wd_span(period, TICKS_PER_SEC, BASE_SEC) - 1);
  assign reload   = cfg_wr && (cfg_restart || (cfg_period != period));
  assign at_last  = (cnt == lim_last);

  assign expire_pulse = !soft_rst && !reload && (period != '0) &&
                        !wd_status && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period    <= PER_DEF;
      cnt       <= '0;
      wd_status <= 1'b0;
    end else if (soft_rst) begin
      period    <= PER_DEF;
      cnt       <= '0;
      wd_status <= 1'b0;
    end else begin
      if (cfg_wr) period <= cfg_period;
      if (reload) begin
        cnt <= '0;
        if (cfg_restart) wd_status <= 1'b0;
      end else if (expire_pulse) begin
        cnt       <= '0;
        wd_status <= 1'b1;
      end else if ((period == '0) || wd_status) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hostwd_evflag.sv
module hostwd_evflag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_pulse,
  input  logic clr_read,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (soft_rst)  flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
    else if (clr_read)  flag <= 1'b0;
  end

endmodule

// File: rtl/hostwd_ctrl.sv
module hostwd_ctrl
  import hostwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wd_expire,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl
);

  ctrl_t nxt;

  always_comb begin
    nxt = ctrl;
    if (wd_expire) begin
      nxt = ctrl_wd_restore(ctrl);
    end else if (wr_en) begin
      case (addr)
        A_ILIM: nxt.ilim = clamp_ilim(wdata[ILIM_W-1:0]);
        A_CONV: begin
          nxt.chg        = wdata[0];
          nxt.load_out   = wdata[1];
          nxt.hiz        = wdata[2];
          nxt.chg_wd_val = wdata[3];
        end
        A_PATH: begin
          nxt.rev         = wdata[0];
          nxt.load_in     = wdata[1];
          nxt.bypass      = wdata[2];
          nxt.adc         = wdata[3];
          nxt.pin_iout    = wdata[4];
          nxt.pin_iin     = wdata[5];
          nxt.adc_oneshot = wdata[6];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl <= ctrl_default();
    else if (soft_rst) ctrl <= ctrl_default();
    else               ctrl <= nxt;
  end

endmodule

// File: rtl/hostwd_regfile.sv
module hostwd_regfile
  import hostwd_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned BASE_SEC      = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        chg_en,
  output logic        hiz_en,
  output logic        rev_en,
  output logic        bypass_en,
  output logic        adc_en,
  output logic        iout_pin_en,
  output logic        iin_pin_en,
  output logic        load_out_en,
  output logic        load_in_en,
  output logic [8:0]  ilim_code,
  output logic        wd_status,
  output logic        wd_flag
);

  // named internal events, visible to the bound checker
  logic             soft_rst_cmd;
  logic             restart_cmd;
  logic             timer_wr;
  logic             wd_expire;
  logic [PER_W-1:0] wd_period;
  logic             chg_wd_sel;
  logic             stat_read;
  ctrl_t            ctrl_q;
  logic [DATA_W-1:0] rd_word;

  assign soft_rst_cmd = wr_en && (addr == A_PATH) && wdata[PATH_SOFTRST_BIT];
  assign timer_wr     = wr_en && (addr == A_TIMER);
  assign restart_cmd  = timer_wr && wdata[TIMER_RESTART_BIT];
  assign stat_read    = rd_en && (addr == A_STAT);

  hostwd_timer #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .BASE_SEC      (BASE_SEC)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst_cmd),
    .tick         (tick),
    .cfg_wr       (timer_wr),
    .cfg_period   (wdata[PER_W-1:0]),
    .cfg_restart  (wdata[TIMER_RESTART_BIT]),
    .period       (wd_period),
    .expire_pulse (wd_expire),
    .wd_status    (wd_status)
  );

  hostwd_evflag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst_cmd),
    .set_pulse (wd_expire),
    .clr_read  (stat_read),
    .flag      (wd_flag)
  );

  hostwd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst_cmd),
    .wd_expire (wd_expire),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .ctrl      (ctrl_q)
  );

  assign chg_wd_sel  = ctrl_q.chg_wd_val;
  assign chg_en      = ctrl_q.chg;
  assign hiz_en      = ctrl_q.hiz;
  assign rev_en      = ctrl_q.rev;
  assign bypass_en   = ctrl_q.bypass;
  assign adc_en      = ctrl_q.adc;
  assign iout_pin_en = ctrl_q.pin_iout;
  assign iin_pin_en  = ctrl_q.pin_iin;
  assign load_out_en = ctrl_q.load_out;
  assign load_in_en  = ctrl_q.load_in;
  assign ilim_code   = ctrl_q.ilim;

  always_comb begin
    rd_word = '0;
    case (addr)
      A_ILIM:  rd_word[ILIM_W-1:0] = ctrl_q.ilim;
      A_TIMER: rd_word[PER_W-1:0]  = wd_period;
      A_CONV:  rd_word[3:0] = {ctrl_q.chg_wd_val, ctrl_q.hiz,
                               ctrl_q.load_out, ctrl_q.chg};
      A_PATH:  rd_word[6:0] = {ctrl_q.adc_oneshot, ctrl_q.pin_iin,
                               ctrl_q.pin_iout, ctrl_q.adc, ctrl_q.bypass,
                               ctrl_q.load_in, ctrl_q.rev};
      A_STAT:  rd_word[1:0] = {wd_flag, wd_status};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

endmodule

// File: rtl/hostwd_checker.sv
module hostwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       expire_pulse,
  input logic       soft_rst,
  input logic       restart_cmd,
  input logic [1:0] period,
  input logic       chg_wd_sel,
  input logic       chg_en,
  input logic       hiz_en,
  input logic       rev_en,
  input logic       bypass_en,
  input logic       adc_en,
  input logic       iout_pin_en,
  input logic       iin_pin_en,
  input logic       load_out_en,
  input logic       load_in_en,
  input logic [8:0] ilim_code,
  input logic       wd_status,
  input logic       wd_flag
);

  p_group_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |=> (!hiz_en && !rev_en && !bypass_en && !adc_en &&
                      !load_out_en && !load_in_en && iout_pin_en &&
                      iin_pin_en && (ilim_code == 9'h190)));

  p_chg_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |=> (chg_en == $past(chg_wd_sel)));

  p_ilim_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_code >= 9'h008) && (ilim_code <= 9'h190));

  p_expire_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |=> (wd_status && wd_flag));

  p_flag_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_status) |-> wd_flag);

  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_cmd |=> !wd_status);

  p_off_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 2'b00) |-> !expire_pulse);

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((period == 2'b01) && !wd_status && !wd_flag && chg_en &&
                  !hiz_en && !rev_en && (ilim_code == 9'h190)));

endmodule

bind hostwd_regfile hostwd_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .expire_pulse (wd_expire),
  .soft_rst     (soft_rst_cmd),
  .restart_cmd  (restart_cmd),
  .period       (wd_period),
  .chg_wd_sel   (chg_wd_sel),
  .chg_en       (chg_en),
  .hiz_en       (hiz_en),
  .rev_en       (rev_en),
  .bypass_en    (bypass_en),
  .adc_en       (adc_en),
  .iout_pin_en  (iout_pin_en),
  .iin_pin_en   (iin_pin_en),
  .load_out_en  (load_out_en),
  .load_in_en   (load_in_en),
  .ilim_code    (ilim_code),
  .wd_status    (wd_status),
  .wd_flag      (wd_flag)
);

// File: tb/hostwd_regfile_test.sv
module hostwd_regfile_test;

  localparam int TPS = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        chg_en, hiz_en, rev_en, bypass_en, adc_en;
  logic        iout_pin_en, iin_pin_en, load_out_en, load_in_en;
  logic [8:0]  ilim_code;
  logic        wd_status, wd_flag;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hostwd_regfile #(.TICKS_PER_SEC(TPS), .BASE_SEC(40)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .chg_en(chg_en),
    .hiz_en(hiz_en), .rev_en(rev_en), .bypass_en(bypass_en),
    .adc_en(adc_en), .iout_pin_en(iout_pin_en), .iin_pin_en(iin_pin_en),
    .load_out_en(load_out_en), .load_in_en(load_in_en),
    .ilim_code(ilim_code), .wd_status(wd_status), .wd_flag(wd_flag)
  );

  // ---------------- behavioural reference model ----------------
  int m_period, m_cnt, m_stat, m_flag, m_rdata;
  int m_chg, m_chgwd, m_lout, m_hiz, m_rev, m_lin, m_byp, m_adc;
  int m_one, m_piout, m_piin, m_ilim;

  task automatic m_defaults();
    m_period = 1; m_cnt = 0; m_stat = 0; m_flag = 0;
    m_chg = 1; m_chgwd = 1; m_lout = 0; m_hiz = 0; m_rev = 0; m_lin = 0;
    m_byp = 0; m_adc = 0; m_one = 1; m_piout = 1; m_piin = 1; m_ilim = 400;
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_ilim;
      1: return m_period;
      2: return m_chg + 2*m_lout + 4*m_hiz + 8*m_chgwd;
      3: return m_rev + 2*m_lin + 4*m_byp + 8*m_adc + 16*m_piout +
                32*m_piin + 64*m_one;
      4: return m_stat + 2*m_flag;
      default: return 0;
    endcase
  endfunction

  function automatic int m_limit(int p);
    if (p == 1) return 40 * TPS;
    if (p == 2) return 80 * TPS;
    if (p == 3) return 160 * TPS;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_defaults();
      m_rdata = 0;
    end else begin
      int a;
      bit expd, rs, pc;
      a = int'(addr);
      expd = 0;
      if (rd_en) m_rdata = m_read(a);
      if (wr_en && a == 3 && wdata[7]) begin
        m_defaults();
      end else begin
        rs = wr_en && a == 1 && wdata[2];
        pc = wr_en && a == 1 && int'(wdata[1:0]) != m_period;
        if (rs || pc) begin
          m_cnt = 0;
          if (rs) m_stat = 0;
        end else if (m_period == 0 || m_stat == 1) begin
          m_cnt = 0;
        end else if (tick) begin
          if (m_cnt + 1 == m_limit(m_period)) begin
            expd = 1; m_cnt = 0; m_stat = 1;
          end else begin
            m_cnt = m_cnt + 1;
          end
        end
        if (wr_en && a == 1) m_period = int'(wdata[1:0]);
        if (expd) m_flag = 1;
        else if (rd_en && a == 4) m_flag = 0;
        if (expd) begin
          m_chg = m_chgwd; m_lout = 0; m_hiz = 0; m_rev = 0; m_lin = 0;
          m_byp = 0; m_adc = 0; m_piout = 1; m_piin = 1; m_ilim = 400;
        end else if (wr_en) begin
          if (a == 0) begin
            m_ilim = int'(wdata[8:0]);
            if (m_ilim < 8) m_ilim = 8;
            if (m_ilim > 400) m_ilim = 400;
          end else if (a == 2) begin
            m_chg = wdata[0]; m_lout = wdata[1]; m_hiz = wdata[2];
            m_chgwd = wdata[3];
          end else if (a == 3) begin
            m_rev = wdata[0]; m_lin = wdata[1]; m_byp = wdata[2];
            m_adc = wdata[3]; m_piout = wdata[4]; m_piin = wdata[5];
            m_one = wdata[6];
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 chg_en model",      chg_en,      m_chg);
      chk("R4 hiz_en model",      hiz_en,      m_hiz);
      chk("R4 rev_en model",      rev_en,      m_rev);
      chk("R4 bypass_en model",   bypass_en,   m_byp);
      chk("R4 adc_en model",      adc_en,      m_adc);
      chk("R4 iout_pin_en model", iout_pin_en, m_piout);
      chk("R4 iin_pin_en model",  iin_pin_en,  m_piin);
      chk("R4 load_out_en model", load_out_en, m_lout);
      chk("R4 load_in_en model",  load_in_en,  m_lin);
      chk("R7 ilim_code model",   ilim_code,   m_ilim);
      chk("R3 wd_status model",   wd_status,   m_stat);
      chk("R3 wd_flag model",     wd_flag,     m_flag);
      chk("R11 rdata model",      rdata,       m_rdata);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog expired: actual=%0d expected<100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 chg_en reset", chg_en, 1);
    chk("R10 pins reset", {iout_pin_en, iin_pin_en}, 3);
    chk("R10 ilim reset", ilim_code, 'h190);
    chk("R10 others reset", {hiz_en, rev_en, bypass_en, adc_en, load_out_en,
                             load_in_en, wd_status, wd_flag}, 0);
    rd(4'd1, v); chk("R1 period default", v, 1);
    rd(4'd2, v); chk("R11 CONV default", v, 'h9);
    rd(4'd3, v); chk("R11 PATH default", v, 'h70);
    rd(4'd0, v); chk("R11 ILIM default", v, 'h190);
    rd(4'd9, v); chk("R11 unmapped read", v, 0);

    // load non-default control values
    wr(4'd2, 16'h000F);
    wr(4'd3, 16'h000F);
    wr(4'd0, 16'h0064);
    chk("R7 ilim in range", ilim_code, 'h64);

    // R1/R3/R4/R5/R6: period 01 expiry with tick every cycle
    tick = 1'b1;
    wr(4'd1, 16'h0005);
    idle(39);
    chk("R1 no expiry at tick 39", wd_status, 0);
    idle(1);
    chk("R1 expiry at tick 40", wd_status, 1);
    chk("R3 flag raised", wd_flag, 1);
    chk("R4 group cleared", {hiz_en, rev_en, bypass_en, adc_en,
                             load_out_en, load_in_en}, 0);
    chk("R4 pins restored", {iout_pin_en, iin_pin_en}, 3);
    chk("R4 ilim restored", ilim_code, 'h190);
    chk("R5 chg to behaviour bit 1", chg_en, 1);
    rd(4'd3, v); chk("R6 PATH after expiry keeps one-shot 0", v, 'h30);
    rd(4'd2, v); chk("R6 CONV keeps behaviour bit", v, 'h9);
    rd(4'd1, v); chk("R6 period unchanged", v, 1);

    // R3: clear on read
    rd(4'd4, v); chk("R3 status read", v, 3);
    rd(4'd4, v); chk("R3 flag cleared by read", v, 1);

    // R5 with behaviour bit 0, R1 period 10, R2 restart clears status
    wr(4'd2, 16'h0001);
    wr(4'd1, 16'h0006);
    chk("R2 restart clears status", wd_status, 0);
    idle(79);
    chk("R1 period 10 no expiry at 79", wd_status, 0);
    idle(1);
    chk("R1 period 10 expiry at 80", wd_status, 1);
    chk("R5 chg to behaviour bit 0", chg_en, 0);

    // R1 period 11
    wr(4'd1, 16'h0007);
    idle(159);
    chk("R1 period 11 no expiry at 159", wd_status, 0);
    idle(1);
    chk("R1 period 11 expiry at 160", wd_status, 1);
    rd(4'd1, v); chk("R2 restart bit reads 0", v, 3);

    // R9: period change restarts count without clearing status
    wr(4'd1, 16'h0005);
    idle(30);
    wr(4'd1, 16'h0002);
    idle(79);
    chk("R9 period change restarts count", wd_status, 0);
    idle(1);
    chk("R9 expiry 80 ticks after change", wd_status, 1);

    // R9: period 00 never expires
    wr(4'd1, 16'h0004);
    idle(400);
    chk("R9 disabled period no expiry", wd_status, 0);

    // R7: clamping
    wr(4'd0, 16'hFE05);
    chk("R7 clamp low", ilim_code, 'h008);
    wr(4'd0, 16'h01FF);
    chk("R7 clamp high", ilim_code, 'h190);
    wr(4'd0, 16'h00AB);
    chk("R7 pass through", ilim_code, 'h0AB);

    // R8: soft reset
    wr(4'd2, 16'h0006);
    wr(4'd3, 16'h000F);
    wr(4'd1, 16'h0003);
    wr(4'd3, 16'h008F);
    chk("R8 outputs default", {chg_en, hiz_en, rev_en, bypass_en, adc_en,
                               iout_pin_en, iin_pin_en}, 'b1000011);
    chk("R8 ilim default", ilim_code, 'h190);
    rd(4'd1, v); chk("R8 period default", v, 1);
    rd(4'd3, v); chk("R8 PATH default, command reads 0", v, 'h70);

    // random traffic against the model
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      tick  = ($urandom % 2) == 0;
      wr_en = ($urandom % 4) == 0;
      rd_en = ($urandom % 3) == 0;
      addr  = 4'($urandom % 6);
      wdata = 16'($urandom);
      if (addr == 4'd3 && ($urandom % 16) != 0) wdata[7] = 1'b0;
      if (addr == 4'd1 && ($urandom % 8) != 0)  wdata[2] = 1'b0;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    idle(2);
    finish_run();
  end

endmodule